// File: doc/BRIEF.md
# Channel-Interleaved Pipelined First-Order IIR Filter

This block applies a one-pole low-pass recursion, `y = k*x + (1-k)*y_prev`, to several independent channels through one arithmetic datapath. Samples arrive one per enabled clock, and their channel index follows a fixed round-robin order. The multiply-add datapath is pipelined over `LAT` register stages. A feedback delay line of `N_CH - LAT` stages returns each result to the datapath input. That result arrives in the slot where the same channel presents its next sample. Pipelining therefore adds throughput without changing any channel's recursion.

A single clock enable advances every register in the block. A system can therefore process one frame of `N_CH` slots per sample period and stall in between. A design with one real channel feeds zeros in the spare slots and gets the same results as a dedicated scalar filter. The smoothing coefficient `k_i` is an unsigned fraction supplied at run time. The block captures it together with its complement `1-k`.

The parameters must satisfy `LAT >= 2` and `N_CH >= LAT`. Any other setting stops elaboration. When `N_CH == LAT`, the output is wired straight back to the datapath input with no delay stages.

Top module: `ilv_iir_filter`

## Requirements
- R1: Each accepted sample produces `y = floor((x*k + y_prev*(2^COEF_W - k)) / 2^COEF_W)`. Here `x` and `y` are two's-complement signed and `k` is unsigned with `COEF_W` fraction bits. With `k = 0` the channel holds its value; with `k = 2^(COEF_W-1)` the output is the floored mean of `x` and `y_prev`.
- R2: A result becomes visible on `y_o` exactly `LAT` enabled cycles after its sample is accepted. At that point `ch_o` carries the channel index that came with the sample.
- R3: `y_prev` is the result of the same channel's previous sample, accepted `N_CH` enabled cycles earlier. Channels do not affect each other.
- R4: `ch_i` must count 0, 1, …, `N_CH-1` and wrap, advancing only on enabled cycles and starting at 0 after reset.
- R5: While `en_i` is low, no state changes and `y_o` and `ch_o` hold. A stream with enable gaps produces the same results as the same stream without gaps.
- R6: Reset clears the outputs and every channel's stored state to zero and resets the captured coefficient to `k = 0`.
- R7: `k_i` is captured on each enabled cycle. A sample accepted in a given enabled cycle uses the `k_i` value captured on the previous enabled cycle.
- R8: With one real channel (channel 0) and zero inputs in the other slots, channel 0 matches a scalar filter and the other slots output 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Clock enable for every register in the block |
| ch_i | input | CH_W | Channel index of the incoming sample |
| x_i | input | DATA_W | Input sample, signed |
| k_i | input | COEF_W | Smoothing coefficient, unsigned fraction |
| y_o | output | DATA_W | Filtered output, signed |
| ch_o | output | CH_W | Channel index of `y_o` |

## Verification
The hardest case to reach is a result returning through the feedback line while the enable is gappy and the coefficient changes from slot to slot. In that case the wrong alignment between a channel's stored value and the coefficient pipeline would go unseen by any steady stream. The bench drives independent random streams on every channel, changes `k_i` on every slot, and inserts random enable gaps. It compares each result with a per-channel scalar model that applies the coefficient captured one enabled cycle earlier. It also applies a reset in the middle of a run, with `k = 0`, to show that every stored channel state was cleared.

// File: rtl/iir_pkg.sv
package iir_pkg;
  function automatic int ch_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/iir_delay_line.sv
module iir_delay_line #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] d_o
);
  logic [WIDTH-1:0] sr_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) sr_q[i] <= '0;
    end else if (en_i) begin
      sr_q[0] <= d_i;
      for (int i = 1; i < DEPTH; i++) sr_q[i] <= sr_q[i-1];
    end
  end

  assign d_o = sr_q[DEPTH-1];
endmodule

// File: rtl/iir_coef_reg.sv
module iir_coef_reg #(
  parameter int COEF_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [COEF_W-1:0] k_i,
  output logic [COEF_W-1:0] k_o,
  output logic [COEF_W:0]   kc_o
);
  localparam logic [COEF_W:0] UNITY = {1'b1, {COEF_W{1'b0}}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      k_o  <= '0;
      kc_o <= UNITY;
    end else if (en_i) begin
      k_o  <= k_i;
      kc_o <= UNITY - {1'b0, k_i};
    end
  end
endmodule

// File: rtl/iir_mac_pipe.sv
module iir_mac_pipe #(
  parameter int DATA_W = 16,
  parameter int COEF_W = 12,
  parameter int CH_W   = 2,
  parameter int LAT    = 3
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     en_i,
  input  logic signed [DATA_W-1:0] x_i,
  input  logic signed [DATA_W-1:0] y_fb_i,
  input  logic [CH_W-1:0]          ch_i,
  input  logic [COEF_W-1:0]        k_i,
  input  logic [COEF_W:0]          kc_i,
  output logic signed [DATA_W-1:0] y_o,
  output logic [CH_W-1:0]          ch_o
);
  localparam int PW    = DATA_W + COEF_W + 2;
  localparam int SW    = PW + 1;
  localparam int TAIL  = LAT - 2;
  localparam int PKT_W = DATA_W + CH_W;

  logic signed [PW-1:0]     px_q, py_q;
  logic [CH_W-1:0]          ch1_q, ch2_q;
  logic signed [SW-1:0]     sum;
  logic signed [DATA_W-1:0] y2_q;

  // stage 1: both products
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      px_q  <= '0;
      py_q  <= '0;
      ch1_q <= '0;
    end else if (en_i) begin
      px_q  <= PW'(x_i) * PW'($signed({1'b0, k_i}));
      py_q  <= PW'(y_fb_i) * PW'($signed({1'b0, kc_i}));
      ch1_q <= ch_i;
    end
  end

  // stage 2: sum and floor-scale; k + (1-k) = 1 keeps the result in range
  assign sum = SW'(px_q) + SW'(py_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      y2_q  <= '0;
      ch2_q <= '0;
    end else if (en_i) begin
      y2_q  <= sum[COEF_W +: DATA_W];
      ch2_q <= ch1_q;
    end
  end

  generate
    if (TAIL == 0) begin : g_no_tail
      assign y_o  = y2_q;
      assign ch_o = ch2_q;
    end else begin : g_tail
      logic [PKT_W-1:0] pkt_out;
      iir_delay_line #(.WIDTH(PKT_W), .DEPTH(TAIL)) u_tail (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .en_i  (en_i),
        .d_i   ({ch2_q, y2_q}),
        .d_o   (pkt_out)
      );
      assign y_o  = pkt_out[DATA_W-1:0];
      assign ch_o = pkt_out[PKT_W-1:DATA_W];
    end
  endgenerate
endmodule

// File: rtl/ilv_iir_filter.sv
module ilv_iir_filter #(
  parameter int DATA_W = 16,
  parameter int COEF_W = 12,
  parameter int N_CH   = 4,
  parameter int LAT    = 3,
  localparam int CH_W  = iir_pkg::ch_width(N_CH)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     en_i,
  input  logic [CH_W-1:0]          ch_i,
  input  logic signed [DATA_W-1:0] x_i,
  input  logic [COEF_W-1:0]        k_i,
  output logic signed [DATA_W-1:0] y_o,
  output logic [CH_W-1:0]          ch_o
);
  localparam int FB_D = N_CH - LAT;

  generate
    if (LAT < 2 || N_CH < LAT) begin : g_bad_cfg
      $error("ilv_iir_filter: need LAT >= 2 and N_CH >= LAT");
    end
  endgenerate

  logic [COEF_W-1:0]        k_q;
  logic [COEF_W:0]          kc_q;
  logic signed [DATA_W-1:0] y_fb;

  iir_coef_reg #(.COEF_W(COEF_W)) u_coef (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (en_i),
    .k_i   (k_i),
    .k_o   (k_q),
    .kc_o  (kc_q)
  );

  iir_mac_pipe #(
    .DATA_W(DATA_W), .COEF_W(COEF_W), .CH_W(CH_W), .LAT(LAT)
  ) u_mac (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (en_i),
    .x_i   (x_i),
    .y_fb_i(y_fb),
    .ch_i  (ch_i),
    .k_i   (k_q),
    .kc_i  (kc_q),
    .y_o   (y_o),
    .ch_o  (ch_o)
  );

  // return path: LAT + FB_D = N_CH enabled cycles per loop turn
  generate
    if (FB_D == 0) begin : g_fb_direct
      assign y_fb = y_o;
    end else begin : g_fb_delay
      logic [DATA_W-1:0] fb_out;
      iir_delay_line #(.WIDTH(DATA_W), .DEPTH(FB_D)) u_fb (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .en_i  (en_i),
        .d_i   (y_o),
        .d_o   (fb_out)
      );
      assign y_fb = $signed(fb_out);
    end
  endgenerate
endmodule

// File: rtl/ilv_iir_filter_chk.sv
module ilv_iir_filter_chk #(
  parameter int DATA_W = 16,
  parameter int COEF_W = 12,
  parameter int N_CH   = 4,
  parameter int LAT    = 3,
  localparam int CH_W  = iir_pkg::ch_width(N_CH)
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     en_i,
  input logic [CH_W-1:0]          ch_i,
  input logic signed [DATA_W-1:0] x_i,
  input logic [COEF_W-1:0]        k_i,
  input logic signed [DATA_W-1:0] y_o,
  input logic [CH_W-1:0]          ch_o
);
  int exp_ch;
  int seen;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exp_ch <= 0;
      seen   <= 0;
    end else if (en_i) begin
      exp_ch <= (exp_ch + 1) % N_CH;
      if (seen < LAT) seen <= seen + 1;
    end
  end

  AST_CH_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |-> (int'(ch_i) == exp_ch)); // R4

  AST_CH_LAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen == LAT) |-> (int'(ch_o) == (exp_ch + N_CH - LAT) % N_CH)); // R2

  AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> ($stable(y_o) && $stable(ch_o))); // R5

  AST_EARLY_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen < LAT) |-> (y_o == '0 && ch_o == '0)); // R6
endmodule

bind ilv_iir_filter ilv_iir_filter_chk #(
  .DATA_W(DATA_W), .COEF_W(COEF_W), .N_CH(N_CH), .LAT(LAT)
) u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .en_i  (en_i),
  .ch_i  (ch_i),
  .x_i   (x_i),
  .k_i   (k_i),
  .y_o   (y_o),
  .ch_o  (ch_o)
);

// File: tb/ilv_iir_filter_tb_top.sv
`timescale 1ns/1ps
module ilv_iir_filter_tb_top;
  localparam int DW = 16;
  localparam int CW = 12;
  localparam int NC = 4;
  localparam int LT = 3;
  localparam int HALF = 2048;

  localparam logic signed [DW-1:0] TBL_X [8] = '{
    16'sd1000, 16'sd1000, -16'sd1000, -16'sd1000,
    16'sd0, 16'sd32767, 16'sd32767, -16'sd32768};
  localparam logic signed [DW-1:0] TBL_Y [8] = '{
    16'sd500, 16'sd750, -16'sd125, -16'sd563,
    -16'sd282, 16'sd16242, 16'sd24504, -16'sd4132};

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic en_i = 1'b0;
  logic [1:0] ch_i = '0;
  logic signed [DW-1:0] x_i = '0;
  logic [CW-1:0] k_i = '0;
  logic signed [DW-1:0] y_o;
  logic [1:0] ch_o;

  always #2.5 clk = ~clk;

  ilv_iir_filter #(.DATA_W(DW), .COEF_W(CW), .N_CH(NC), .LAT(LT)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en_i), .ch_i(ch_i),
    .x_i(x_i), .k_i(k_i), .y_o(y_o), .ch_o(ch_o));

  int n_run = 0;
  int n_fail = 0;
  string cur_tag = "R1";

  logic signed [DW-1:0] yref [NC];
  logic signed [DW-1:0] exp_y [64];
  int exp_c [64];
  int acc;
  int ch_cnt;
  logic [CW-1:0] kq_m;

  function automatic logic signed [DW-1:0] ref_step(input longint x, input longint yp, input longint k);
    longint s;
    s = x * k + yp * (longint'(1 << CW) - k);
    return DW'(s >>> CW);
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < NC; i++) yref[i] = '0;
    acc = 0;
    ch_cnt = 0;
    kq_m = '0;
  endtask

  // called at a negedge; returns at the next negedge
  task automatic step(input logic en, input logic signed [DW-1:0] x, input logic [CW-1:0] k,
                      input logic ovr, input logic signed [DW-1:0] ovr_y);
    logic signed [DW-1:0] prev_y;
    logic [1:0] prev_c;
    logic signed [DW-1:0] e;
    int idx;
    prev_y = y_o;
    prev_c = ch_o;
    en_i = en;
    ch_i = 2'(ch_cnt);
    x_i = x;
    k_i = k;
    @(posedge clk);
    @(negedge clk);
    if (en) begin
      e = ovr ? ovr_y : ref_step(longint'(x), longint'(yref[ch_cnt]), longint'(kq_m));
      yref[ch_cnt] = e;
      exp_y[acc % 64] = e;
      exp_c[acc % 64] = ch_cnt;
      kq_m = k;
      acc++;
      ch_cnt = (ch_cnt + 1) % NC;
      if (acc >= LT) begin
        idx = (acc - LT) % 64;
        chk(y_o == exp_y[idx], cur_tag, longint'(y_o), longint'(exp_y[idx]));
        chk(int'(ch_o) == exp_c[idx], "R2/R4 ch_o", longint'(ch_o), longint'(exp_c[idx]));
      end
    end else begin
      chk(y_o == prev_y && ch_o == prev_c, "R5 hold", longint'(y_o), longint'(prev_y));
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    en_i = 1'b0;
    repeat (3) @(negedge clk);
    chk(y_o == '0, "R6 y_o in reset", longint'(y_o), 0);
    chk(ch_o == '0, "R6 ch_o in reset", longint'(ch_o), 0);
    rst_ni = 1'b1;
    model_clear();
    @(negedge clk);
  endtask

  initial begin
    model_clear();
    do_reset();

    // single real channel against the hand-computed vector table
    cur_tag = "R8";
    for (int s = 0; s < NC; s++) step(1'b1, '0, CW'(HALF), 1'b0, '0);
    for (int r = 0; r < 8; r++) begin
      cur_tag = "R1";
      step(1'b1, TBL_X[r], CW'(HALF), 1'b1, TBL_Y[r]);
      cur_tag = "R8";
      for (int s = 1; s < NC; s++) step(1'b1, '0, CW'(HALF), 1'b0, '0);
    end

    // coefficient extremes
    cur_tag = "R1";
    for (int f = 0; f < 6; f++)
      for (int s = 0; s < NC; s++) step(1'b1, DW'($urandom), '0, 1'b0, '0);
    for (int f = 0; f < 6; f++)
      for (int s = 0; s < NC; s++) step(1'b1, DW'($urandom), CW'((1 << CW) - 1), 1'b0, '0);

    // independent channels, fixed k
    cur_tag = "R3";
    begin
      logic [CW-1:0] kf;
      kf = CW'($urandom);
      for (int f = 0; f < 200; f++)
        for (int s = 0; s < NC; s++) step(1'b1, DW'($urandom), kf, 1'b0, '0);
    end

    // coefficient changes every slot
    cur_tag = "R7";
    for (int f = 0; f < 200; f++)
      for (int s = 0; s < NC; s++) step(1'b1, DW'($urandom), CW'($urandom), 1'b0, '0);

    // random enable gaps with changing inputs while stalled
    cur_tag = "R5";
    for (int i = 0; i < 1500; i++)
      step(($urandom % 4) != 0, DW'($urandom), CW'($urandom), 1'b0, '0);

    // reset mid-run: every channel must restart from zero
    do_reset();
    cur_tag = "R6";
    for (int f = 0; f < 3; f++)
      for (int s = 0; s < NC; s++) step(1'b1, DW'($urandom), '0, 1'b0, '0);
    for (int f = 0; f < 20; f++)
      for (int s = 0; s < NC; s++) step(1'b1, DW'($urandom), CW'($urandom), 1'b0, '0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule